// File: doc/BRIEF.md
# USB2 PHY Port Control Register Bank

This block is a small bank of 16-bit control and status words that sits between a simple register bus and one USB2 PHY port. Each 32-bit bus write carries its own bit mask: the upper half says which bits of the lower half actually land. Software can therefore flip a single field, such as a clock-stop bit or one detect enable, without first reading the word back.

The bank drives the port's suspend word and the clock-stop control of the PHY's high-speed output clock. It also holds a line-state watcher. While the watcher is armed, any change of the synchronised two-bit line state sets a sticky flag. The flag raises an interrupt and stays set until software writes a one to a separate clear bit. The live line state and host-disconnect signals from the PHY are resynchronised and can be read back as read-only fields.

The bus is a plain single-cycle port. A write takes effect on the clock edge where `bus_sel` and `bus_wr` are both high. A read request is taken on the same kind of edge with `bus_wr` low, and its data appears on `bus_rdata` after that edge. This register-access port has no back-pressure: every access completes in one cycle, so no valid/ready pair is needed.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write, data bit n (0 to 15) of an addressed register changes only when bit n+16 of `bus_wdata` is 1. A write whose mask half is zero leaves the register unchanged.
- R2: The suspend word at byte offset 0x728 uses bits 15:0 and drives `phy_suspend` directly. It resets to 0x0000, which means resumed. Writing 0x01d1 suspends the port.
- R3: Bit 15 at offset 0x724 drives `phy_clk_stop`: 1 stops the PHY clock and 0 lets it run. It resets to 0. The other bits of that word read as 0.
- R4: Detect enable is bit 4 at offset 0x680 and resets to 0. The other bits of that word read as 0.
- R5: While detect is enabled, any change of the synchronised line state sets the sticky status, which reads as bit 4 at offset 0x690. The status holds until it is cleared. Writes to 0x690 have no effect on it.
- R6: A write to offset 0x6a0 with data bit 4 = 1 and mask bit 20 = 1 clears the status. If the mask bit is clear, the write has no effect. Offset 0x6a0 always reads 0. When a set and a clear fall on the same cycle, the set wins.
- R7: `ls_irq` is high exactly when the status and the enable are both 1.
- R8: At offset 0x49c, bits 14:13 return the line state and bit 12 returns the host-disconnect flag. Both pass through SYNC_STAGES flops first. Writes to 0x49c have no effect.
- R9: Read data appears on `bus_rdata` in the cycle after the request. Bits 31:16 are always 0, and unmapped offsets read as 0.
- R10: While detect is disabled, line-state changes leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Registered read data |
| utmi_ls | input | 2 | Live line state from the PHY |
| utmi_hdisc | input | 1 | Host-disconnect flag from the PHY |
| phy_suspend | output | 16 | Port suspend word |
| phy_clk_stop | output | 1 | 1 = PHY output clock stopped |
| ls_irq | output | 1 | Line-state change interrupt |

## Verification
The bench builds the block with ADDR_W = 12 and SYNC_STAGES = 2. The short synchroniser gives a known three-edge path from a pin change to the status flop. With that path fixed, the bench can place a clear write on exactly the edge where a change is detected, and so test that the set wins. Partial masks on the suspend word, together with mask-only and data-only writes, check that only the chosen bits land.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_LINE  = 12'h49C;
  localparam logic [OFS_W-1:0] OFS_DETEN = 12'h680;
  localparam logic [OFS_W-1:0] OFS_DETST = 12'h690;
  localparam logic [OFS_W-1:0] OFS_DETCL = 12'h6A0;
  localparam logic [OFS_W-1:0] OFS_CLK   = 12'h724;
  localparam logic [OFS_W-1:0] OFS_SUSP  = 12'h728;
  localparam int WORD_W   = 16;
  localparam int MASK_SH  = 16;
  localparam int DET_BIT  = 4;
  localparam int CLK_BIT  = 15;
  localparam int LS_LSB   = 13;
  localparam int HD_BIT   = 12;
  localparam int LS_W     = 2;
endpackage

// File: rtl/wmask_reg.sv
module wmask_reg #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [WIDTH-1:0] wbits,
  input  logic [WIDTH-1:0] wmask,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                q[i] <= RESET[i];
      else if (wr && wmask[i])   q[i] <= wbits[i];
    end
  end
endmodule

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ls_watch.sv
module ls_watch #(
  parameter int LSW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [LSW-1:0] ls,
  input  logic           arm,
  input  logic           clr,
  output logic           flag,
  output logic           chg
);
  logic [LSW-1:0] ls_prev;

  assign chg = (ls != ls_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_prev <= '0;
      flag    <= 1'b0;
    end else begin
      ls_prev <= ls;
      if (arm && chg)  flag <= 1'b1;
      else if (clr)    flag <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_ctl_regbank.sv
module phy_ctl_regbank
  import phy_ctl_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [1:0]        utmi_ls,
  input  logic              utmi_hdisc,
  output logic [15:0]       phy_suspend,
  output logic              phy_clk_stop,
  output logic              ls_irq
);
  localparam int SYW = LS_W + 1;

  logic [WORD_W-1:0] wbits, wmask;
  logic              wr_q;
  logic              hit_line, hit_en, hit_st, hit_cl, hit_clk, hit_susp;
  logic              det_en_q, det_st_q, det_clr, det_chg;
  logic [SYW-1:0]    sy_in, sy_out;
  logic [LS_W-1:0]   ls_s;
  logic              hd_s;
  logic [31:0]       rd_mux;

  assign wbits = bus_wdata[WORD_W-1:0];
  assign wmask = bus_wdata[MASK_SH+WORD_W-1:MASK_SH];
  assign wr_q  = bus_sel && bus_wr;

  assign hit_line = (bus_addr == ADDR_W'(OFS_LINE));
  assign hit_en   = (bus_addr == ADDR_W'(OFS_DETEN));
  assign hit_st   = (bus_addr == ADDR_W'(OFS_DETST));
  assign hit_cl   = (bus_addr == ADDR_W'(OFS_DETCL));
  assign hit_clk  = (bus_addr == ADDR_W'(OFS_CLK));
  assign hit_susp = (bus_addr == ADDR_W'(OFS_SUSP));

  wmask_reg #(.WIDTH(WORD_W), .RESET(16'h0000)) u_susp (
    .clk(clk), .rst_n(rst_n), .wr(wr_q && hit_susp),
    .wbits(wbits), .wmask(wmask), .q(phy_suspend)
  );

  wmask_reg #(.WIDTH(1), .RESET(1'b0)) u_clk (
    .clk(clk), .rst_n(rst_n), .wr(wr_q && hit_clk),
    .wbits(wbits[CLK_BIT]), .wmask(wmask[CLK_BIT]), .q(phy_clk_stop)
  );

  wmask_reg #(.WIDTH(1), .RESET(1'b0)) u_den (
    .clk(clk), .rst_n(rst_n), .wr(wr_q && hit_en),
    .wbits(wbits[DET_BIT]), .wmask(wmask[DET_BIT]), .q(det_en_q)
  );

  assign det_clr = wr_q && hit_cl && wbits[DET_BIT] && wmask[DET_BIT];

  assign sy_in = {utmi_ls, utmi_hdisc};
  sync_chain #(.WIDTH(SYW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sy_in), .q(sy_out)
  );
  assign ls_s = sy_out[SYW-1:1];
  assign hd_s = sy_out[0];

  ls_watch #(.LSW(LS_W)) u_watch (
    .clk(clk), .rst_n(rst_n), .ls(ls_s), .arm(det_en_q),
    .clr(det_clr), .flag(det_st_q), .chg(det_chg)
  );

  assign ls_irq = det_st_q && det_en_q;

  always_comb begin
    rd_mux = '0;
    if (hit_line) begin
      rd_mux[LS_LSB +: LS_W] = ls_s;
      rd_mux[HD_BIT]         = hd_s;
    end
    if (hit_clk)  rd_mux[CLK_BIT]      = phy_clk_stop;
    if (hit_susp) rd_mux[WORD_W-1:0]   = phy_suspend;
    if (hit_en)   rd_mux[DET_BIT]      = det_en_q;
    if (hit_st)   rd_mux[DET_BIT]      = det_st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/phy_ctl_regbank_chk.sv
module phy_ctl_regbank_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [15:0]       phy_suspend,
  input logic              ls_irq,
  input logic              det_en,
  input logic              det_st,
  input logic              det_clr,
  input logic              det_chg
);
  logic susp_nomask;
  assign susp_nomask = bus_sel && bus_wr && (bus_addr == ADDR_W'(12'h728))
                       && (bus_wdata[31:16] == 16'h0000);

  // R1
  susp_nomask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    susp_nomask |=> $stable(phy_suspend));

  // R5
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_st && !det_clr) |=> det_st);

  // R6
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_clr && !(det_chg && det_en)) |=> !det_st);

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_clr && det_chg && det_en) |=> det_st);

  // R10
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !det_st) |=> !det_st);

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ls_irq |-> (det_en && det_st));

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0000);
endmodule

bind phy_ctl_regbank phy_ctl_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .phy_suspend(phy_suspend), .ls_irq(ls_irq), .det_en(det_en_q),
  .det_st(det_st_q), .det_clr(det_clr), .det_chg(det_chg)
);

// File: tb/tb_phy_ctl_regbank.sv
`timescale 1ns/1ps
module tb_phy_ctl_regbank;
  localparam int AW = 12;
  localparam int SS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [1:0]    utmi_ls = 2'b00;
  logic          utmi_hdisc = 1'b0;
  logic [15:0]   phy_suspend;
  logic          phy_clk_stop, ls_irq;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #4 clk = ~clk;

  phy_ctl_regbank #(.ADDR_W(AW), .SYNC_STAGES(SS)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .utmi_ls(utmi_ls), .utmi_hdisc(utmi_hdisc), .phy_suspend(phy_suspend),
    .phy_clk_stop(phy_clk_stop), .ls_irq(ls_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R9: unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // reset state
    check({16'h0, phy_suspend}, 32'h0, "R2 reset suspend");
    check({31'h0, phy_clk_stop}, 32'h0, "R3 reset clk stop");
    check({31'h0, ls_irq}, 32'h0, "R7 reset irq");
    rd(12'h680, 32'h0, "R4 reset enable");
    // R2 suspend / resume
    wr(12'h728, 32'hFFFF_01D1);
    check({16'h0, phy_suspend}, 32'h01D1, "R2 suspend pin");
    rd(12'h728, 32'h0000_01D1, "R2 suspend read");
    // R1 partial mask and empty mask
    wr(12'h728, 32'h00FF_0022);
    check({16'h0, phy_suspend}, 32'h0122, "R1 low byte only");
    wr(12'h728, 32'h0000_FFFF);
    check({16'h0, phy_suspend}, 32'h0122, "R1 empty mask");
    wr(12'h728, 32'hFFFF_0000);
    check({16'h0, phy_suspend}, 32'h0000, "R2 resume");
    // R3 clock stop
    wr(12'h724, 32'h8000_8000);
    check({31'h0, phy_clk_stop}, 32'h1, "R3 stop");
    rd(12'h724, 32'h0000_8000, "R3 read");
    wr(12'h724, 32'h7FFF_0000);
    check({31'h0, phy_clk_stop}, 32'h1, "R1 clk mask clear");
    wr(12'h724, 32'h8000_0000);
    check({31'h0, phy_clk_stop}, 32'h0, "R3 run");
    // R10 change while disabled
    utmi_ls = 2'b01;
    idle(5);
    rd(12'h690, 32'h0, "R10 no set while disabled");
    // R4 enable
    wr(12'h680, 32'h00FF_00FF);
    rd(12'h680, 32'h0000_0010, "R4 enable read");
    // R8 + R5
    utmi_ls = 2'b10; utmi_hdisc = 1'b1;
    idle(5);
    rd(12'h49C, 32'h0000_5000, "R8 live fields");
    rd(12'h690, 32'h0000_0010, "R5 status set");
    check({31'h0, ls_irq}, 32'h1, "R7 irq high");
    wr(12'h49C, 32'hFFFF_0000);
    rd(12'h49C, 32'h0000_5000, "R8 write ignored");
    utmi_ls = 2'b10;
    wr(12'h690, 32'hFFFF_0000);
    rd(12'h690, 32'h0000_0010, "R5 status write ignored");
    // R6 clear
    wr(12'h6A0, 32'h0010_0000);
    rd(12'h690, 32'h0000_0010, "R6 data-less clear ignored");
    wr(12'h6A0, 32'h0000_0010);
    rd(12'h690, 32'h0000_0010, "R6 mask-less clear ignored");
    wr(12'h6A0, 32'h0010_0010);
    rd(12'h690, 32'h0, "R6 cleared");
    check({31'h0, ls_irq}, 32'h0, "R7 irq low after clear");
    rd(12'h6A0, 32'h0, "R6 clear reads zero");
    // R7 irq gated by enable
    utmi_ls = 2'b11;
    idle(5);
    check({31'h0, ls_irq}, 32'h1, "R7 irq on change");
    wr(12'h680, 32'h0010_0000);
    check({31'h0, ls_irq}, 32'h0, "R7 irq off when disabled");
    rd(12'h690, 32'h0000_0010, "R7 status kept");
    wr(12'h6A0, 32'h0010_0010);
    wr(12'h680, 32'h0010_0010);
    idle(2);
    // R6 set beats clear on the same edge
    @(negedge clk);
    utmi_ls = 2'b00;
    repeat (SS) @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h6A0; bus_wdata = 32'h0010_0010;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    rd(12'h690, 32'h0000_0010, "R6 set wins over clear");
    // R9 unmapped
    rd(12'h100, 32'h0, "R9 unmapped zero");
    rd(12'h72C, 32'h0, "R9 unmapped near suspend");
    idle(3);
    if (exp_q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R9: pending reads actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule